// File: doc/BRIEF.md
# Branch Decision Bit Packer

This block sits beside an instruction retirement interface and turns a stream of one-bit control-flow outcomes into compact decision packets for a trace stream. Each retired conditional branch gives one bit: 1 when taken, 0 when not. Each return whose return address was left unmodified gives a single 1 bit. Bits are gathered oldest-first into an accumulator. A packet is sealed and handed to a byte-wide valid/ready output as soon as the accumulator reaches the capacity of the selected form. The short form holds six decisions in one byte. The long form holds forty-seven decisions in eight bytes.

When the surrounding trace logic has some other packet to send, it raises a flush request. The packer then seals whatever it holds as a partial packet, so decision bits never fall behind a later packet in the stream. The surrounding logic may emit its own packet once the `drained` output shows that nothing is pending or in flight. A stop bit placed just above the newest decision lets a decoder recover how many decisions a packet carries.

Top module: `bdp_packer`

## Requirements
- R1: A conditional branch (dec_is_ret=0) contributes dec_taken as its bit (1 taken, 0 not taken). An unmodified return (dec_is_ret=1) contributes a 1 whatever dec_taken is.
- R2: A short packet is one byte with pkt_last=1. Bit 0 is 0, decision k (k=0 oldest) sits at bit k+1, a stop bit of 1 sits at bit n+1 for n decisions, and every bit above it is 0.
- R3: In short mode the packet is sealed without any flush when the sixth decision is accepted, and its byte is valid on pkt_data in the cycle after that acceptance edge.
- R4: A long packet is eight bytes: 0x02, then 0xA3, then a 48-bit payload sent least significant byte first. Decision k is at payload bit k, the stop bit is at payload bit n, and all higher bits are 0. pkt_last is 1 only on the eighth byte.
- R5: In long mode the packet is sealed without any flush when the forty-seventh decision is accepted.
- R6: A flush_req while decisions are pending seals them as a partial packet. A decision accepted in the same cycle as flush_req is included in that packet.
- R7: A flush_req with no pending decisions and none arriving produces no output byte.
- R8: dec_ready is 0 while the accumulator holds a full packet that cannot yet be sealed because the output is still busy. No offered decision is lost, and dec_ready is 1 whenever drained is 1.
- R9: While pkt_valid=1 and pkt_ready=0, pkt_valid, pkt_data and pkt_last hold their values.
- R10: drained is 1 exactly when no decision is pending and no packet byte is waiting on the output. pkt_valid is never 1 while drained is 1.
- R11: long_mode is taken into account only while the accumulator is empty. A change made while decisions are pending applies from the next packet on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_mode | input | 1 | 1 selects the 47-decision form, 0 the 6-decision form |
| dec_valid | input | 1 | A retired branch or return offers a decision |
| dec_is_ret | input | 1 | The decision comes from an unmodified return |
| dec_taken | input | 1 | Outcome of a conditional branch |
| dec_ready | output | 1 | The packer accepts the offered decision this cycle |
| flush_req | input | 1 | Another packet is waiting; seal pending decisions |
| drained | output | 1 | Nothing pending and nothing in flight |
| pkt_valid | output | 1 | A packet byte is presented |
| pkt_ready | input | 1 | The consumer takes the presented byte |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | The presented byte ends its packet |

## Verification
The packer is driven with mixed taken, not-taken and return decisions, including a return whose taken input is 0. This separates the two bit sources. Full short and long packets filled with fixed patterns show where the decisions, the stop bit and the header bytes land in each form. Flushes are given with a decision arriving in the same cycle, with nothing pending, and after a mode switch while decisions are pending. Each of these tells apart in-packet inclusion, silent empty flushes and mode latching. A stalled output while decisions keep arriving exercises backpressure and the hold rules at the byte interface.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  parameter int unsigned SHORT_CAP  = 6;
  parameter int unsigned LONG_CAP   = 47;
  parameter int unsigned BYTE_W     = 8;
  parameter int unsigned LONG_BYTES = 8;
  parameter int unsigned CNT_W      = $clog2(LONG_CAP + 1);
  parameter int unsigned PKT_W      = BYTE_W * LONG_BYTES;
  parameter int unsigned LEN_W      = $clog2(LONG_BYTES + 1);
  parameter logic [BYTE_W-1:0] LONG_HDR_B0 = 8'h02;
  parameter logic [BYTE_W-1:0] LONG_HDR_B1 = 8'hA3;

  typedef struct packed {
    logic [PKT_W-1:0] image;
    logic [LEN_W-1:0] nbytes;
  } pkt_t;
endpackage

// File: rtl/bdp_accum.sv
module bdp_accum import bdp_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                long_mode,
  input  logic                in_valid,
  input  logic                in_bit,
  input  logic                flush_req,
  input  logic                seal_ok,
  output logic                in_ready,
  output logic                seal,
  output logic [LONG_CAP-1:0] seal_bits,
  output logic [CNT_W-1:0]    seal_cnt,
  output logic                seal_long,
  output logic                empty
);
  logic [LONG_CAP-1:0] bits_q, bits_d, bits_sum;
  logic [CNT_W-1:0]    cnt_q, cnt_d, cnt_sum, cap;
  logic                mode_q, mode_d, eff_long, accept, upd_en;

  // next-state logic
  always_comb begin
    eff_long = (cnt_q == '0) ? long_mode : mode_q;
    cap      = eff_long ? CNT_W'(LONG_CAP) : CNT_W'(SHORT_CAP);
    in_ready = (cnt_q < cap);
    accept   = in_valid && in_ready;
    bits_sum = bits_q;
    if (accept) begin
      bits_sum[cnt_q] = in_bit;
    end
    cnt_sum  = cnt_q + CNT_W'(accept);
    seal     = seal_ok && (cnt_sum != '0) && ((cnt_sum == cap) || flush_req);
    cnt_d    = seal ? '0 : cnt_sum;
    bits_d   = seal ? '0 : bits_sum;
    mode_d   = eff_long;
    upd_en   = accept || seal;
  end

  assign seal_bits = bits_sum;
  assign seal_cnt  = cnt_sum;
  assign seal_long = eff_long;
  assign empty     = (cnt_q == '0);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (upd_en) begin
        bits_q <= bits_d;
        cnt_q  <= cnt_d;
      end
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/bdp_format.sv
module bdp_format import bdp_pkg::*; (
  input  logic [LONG_CAP-1:0] bits,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                is_long,
  output pkt_t                pkt
);
  // decisions plus one stop bit
  logic [LONG_CAP:0] body;

  always_comb begin
    body = '0;
    for (int i = 0; i < int'(LONG_CAP); i++) begin
      body[i] = (i < int'(cnt)) ? bits[i] : 1'b0;
    end
    body[cnt] = 1'b1;
    pkt.image = '0;
    if (is_long) begin
      pkt.image  = {body, LONG_HDR_B1, LONG_HDR_B0};
      pkt.nbytes = LEN_W'(LONG_BYTES);
    end else begin
      pkt.image[BYTE_W-1:0] = {body[SHORT_CAP:0], 1'b0};
      pkt.nbytes = LEN_W'(1);
    end
  end
endmodule

// File: rtl/bdp_serial.sv
module bdp_serial import bdp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  pkt_t              load_pkt,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              busy
);
  logic [PKT_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             en;

  assign busy      = (left_q != '0);
  assign out_valid = busy;
  assign out_data  = sh_q[BYTE_W-1:0];
  assign out_last  = (left_q == LEN_W'(1));

  // next-state logic
  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    en     = 1'b0;
    if (load) begin
      sh_d   = load_pkt.image;
      left_d = load_pkt.nbytes;
      en     = 1'b1;
    end else if (busy && out_ready) begin
      sh_d   = sh_q >> BYTE_W;
      left_d = left_q - LEN_W'(1);
      en     = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/bdp_packer.sv
module bdp_packer import bdp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_mode,
  input  logic              dec_valid,
  input  logic              dec_is_ret,
  input  logic              dec_taken,
  output logic              dec_ready,
  input  logic              flush_req,
  output logic              drained,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [BYTE_W-1:0] pkt_data,
  output logic              pkt_last
);
  logic                dec_bit, seal, seal_long, acc_empty, ser_busy;
  logic [LONG_CAP-1:0] seal_bits;
  logic [CNT_W-1:0]    seal_cnt;
  pkt_t                built;

  // an unmodified return always counts as taken
  assign dec_bit = dec_is_ret | dec_taken;

  bdp_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_mode (long_mode),
    .in_valid  (dec_valid),
    .in_bit    (dec_bit),
    .flush_req (flush_req),
    .seal_ok   (!ser_busy),
    .in_ready  (dec_ready),
    .seal      (seal),
    .seal_bits (seal_bits),
    .seal_cnt  (seal_cnt),
    .seal_long (seal_long),
    .empty     (acc_empty)
  );

  bdp_format u_format (
    .bits    (seal_bits),
    .cnt     (seal_cnt),
    .is_long (seal_long),
    .pkt     (built)
  );

  bdp_serial u_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (seal),
    .load_pkt  (built),
    .out_ready (pkt_ready),
    .out_valid (pkt_valid),
    .out_data  (pkt_data),
    .out_last  (pkt_last),
    .busy      (ser_busy)
  );

  assign drained = acc_empty && !ser_busy;
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_valid,
  input logic       dec_ready,
  input logic       flush_req,
  input logic       drained,
  input logic       pkt_valid,
  input logic       pkt_ready,
  input logic [7:0] pkt_data,
  input logic       pkt_last
);
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> !pkt_valid);

  p_empty_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drained && flush_req && !dec_valid) |=> !pkt_valid);

  p_long_header_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pkt_valid) && !pkt_last) |-> (pkt_data == 8'h02));

  p_short_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pkt_valid) && pkt_last) |-> (!pkt_data[0] && (pkt_data != 8'h00)));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> dec_ready);
endmodule

bind bdp_packer bdp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .dec_ready (dec_ready),
  .flush_req (flush_req),
  .drained   (drained),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .pkt_data  (pkt_data),
  .pkt_last  (pkt_last)
);

// File: tb/bdp_packer_bench.sv
`timescale 1ns/1ps
module bdp_packer_bench;
  logic       clk, rst_n, long_mode, dec_valid, dec_is_ret, dec_taken, flush_req, pkt_ready;
  logic       dec_ready, drained, pkt_valid, pkt_last;
  logic [7:0] pkt_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model state
  int         m_pend[$];
  logic [7:0] m_ser[$];
  bit         m_long;
  logic [7:0] log_q[$];

  bdp_packer u_bdp_packer (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .dec_valid(dec_valid),
    .dec_is_ret(dec_is_ret), .dec_taken(dec_taken), .dec_ready(dec_ready),
    .flush_req(flush_req), .drained(drained), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_last(pkt_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic int cap_now();
    bit eff;
    eff = (m_pend.size() == 0) ? long_mode : m_long;
    return eff ? 47 : 6;
  endfunction

  task automatic model_edge();
    bit eff, acc, busy_old;
    int cap, n;
    logic [47:0] pay;
    logic [7:0]  b;
    eff = (m_pend.size() == 0) ? long_mode : m_long;
    cap = eff ? 47 : 6;
    acc = dec_valid && (m_pend.size() < cap);
    busy_old = (m_ser.size() != 0);
    if (busy_old && pkt_ready) void'(m_ser.pop_front());
    if (acc) m_pend.push_back((dec_is_ret || dec_taken) ? 1 : 0);
    if (!busy_old && m_pend.size() > 0 && (m_pend.size() == cap || flush_req)) begin
      n = m_pend.size();
      if (eff) begin
        pay = '0;
        for (int i = 0; i < n; i++) pay[i] = m_pend[i][0];
        pay[n] = 1'b1;
        m_ser.push_back(8'h02);
        m_ser.push_back(8'hA3);
        for (int k = 0; k < 6; k++) m_ser.push_back(pay[8*k +: 8]);
      end else begin
        b = '0;
        for (int i = 0; i < n; i++) b[i+1] = m_pend[i][0];
        b[n+1] = 1'b1;
        m_ser.push_back(b);
      end
      m_pend.delete();
    end
    m_long = eff;
  endtask

  task automatic compare();
    bit mv;
    mv = (m_ser.size() != 0);
    chk(dec_ready == (m_pend.size() < cap_now()), "R8 dec_ready", dec_ready, m_pend.size() < cap_now());
    chk(pkt_valid == mv, "R3 pkt_valid timing", pkt_valid, mv);
    chk(drained == (m_pend.size() == 0 && !mv), "R10 drained", drained, m_pend.size() == 0 && !mv);
    if (mv && pkt_valid) begin
      chk(pkt_data == m_ser[0], "R2 pkt_data", pkt_data, m_ser[0]);
      chk(pkt_last == (m_ser.size() == 1), "R9 pkt_last", pkt_last, m_ser.size() == 1);
    end
  endtask

  task automatic step();
    if (pkt_valid && pkt_ready) log_q.push_back(pkt_data);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic give(bit tk, bit ret, bit fl);
    dec_valid = 1'b1; dec_taken = tk; dec_is_ret = ret; flush_req = fl;
    step();
    dec_valid = 1'b0; dec_taken = 1'b0; dec_is_ret = 1'b0; flush_req = 1'b0;
  endtask

  task automatic drain();
    pkt_ready = 1'b1; dec_valid = 1'b0; flush_req = 1'b0;
    for (int g = 0; g < 40 && !drained; g++) step();
    step();
  endtask

  task automatic expect_bytes(string req, logic [7:0] e[$]);
    chk(log_q.size() == e.size(), {req, " byte count"}, log_q.size(), e.size());
    for (int i = 0; i < e.size() && i < log_q.size(); i++)
      chk(log_q[i] == e[i], {req, " packet byte"}, log_q[i], e[i]);
    log_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; long_mode = 1'b0; dec_valid = 1'b0; dec_is_ret = 1'b0;
    dec_taken = 1'b0; flush_req = 1'b0; pkt_ready = 1'b1;
    m_long = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pkt_valid, "R10 reset pkt_valid", pkt_valid, 0);
    chk(dec_ready, "R8 reset dec_ready", dec_ready, 1);
    chk(drained, "R10 reset drained", drained, 1);

    // R1 and R2: taken, not taken, return with taken=0, then flush
    give(1, 0, 0); give(0, 0, 0); give(0, 1, 1);
    drain();
    expect_bytes("R1 R2", '{8'h1A});

    // R3: six decisions seal on their own
    give(1, 0, 0); give(1, 0, 0); give(0, 0, 0); give(0, 0, 0); give(1, 0, 0);
    give(0, 0, 0);
    chk(pkt_valid && pkt_data == 8'hA6, "R3 byte after sixth", pkt_data, 8'hA6);
    drain();
    expect_bytes("R3", '{8'hA6});

    // R7: empty flush is silent
    flush_req = 1'b1;
    repeat (4) step();
    flush_req = 1'b0;
    chk(!pkt_valid, "R7 no output", pkt_valid, 0);
    expect_bytes("R7", '{});

    // R4 and R5: 47 taken decisions in long mode
    long_mode = 1'b1;
    for (int i = 0; i < 47; i++) give(1, 0, 0);
    chk(pkt_valid && pkt_data == 8'h02, "R5 seal at 47", pkt_data, 8'h02);
    drain();
    expect_bytes("R4 R5", '{8'h02, 8'hA3, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF});

    // R6: nine decisions, tenth arrives with the flush
    for (int i = 0; i < 9; i++) give((i % 2) == 0, 0, 0);
    give(0, 0, 1);
    drain();
    expect_bytes("R6", '{8'h02, 8'hA3, 8'h55, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00});

    // R11: mode change while pending applies to the next packet
    long_mode = 1'b0;
    give(1, 0, 0); give(1, 0, 0);
    long_mode = 1'b1;
    give(1, 0, 1);
    drain();
    expect_bytes("R11 pending stays short", '{8'h1E});
    give(0, 0, 1);
    drain();
    expect_bytes("R11 next is long", '{8'h02, 8'hA3, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});

    // R8 and R9: stalled output with decisions still offered
    long_mode = 1'b0;
    pkt_ready = 1'b0;
    dec_valid = 1'b1; dec_taken = 1'b0; dec_is_ret = 1'b0;
    for (int i = 0; i < 12; i++) step();
    chk(!dec_ready, "R8 full and stalled", dec_ready, 0);
    held = pkt_data;
    step();
    chk(pkt_valid && pkt_data == held, "R9 held while stalled", pkt_data, held);
    dec_valid = 1'b0;
    drain();
    expect_bytes("R8 nothing lost", '{8'h80, 8'h80});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule